// File: doc/BRIEF.md
# Load Alignment and Extension Unit

This block sits between the load stage of a pipeline and a 32-bit data memory that is addressed by byte and read one whole word at a time. A request carries a byte address, an access size, a signed/unsigned flag, a byte-order bit and an unaligned-access policy. The block reads one or two aligned memory words. It picks out the operand bytes, puts them in order for the selected byte order, and widens the result to 32 bits with either zero or sign extension.

Each request picks one of three behaviours for an unaligned operand. The truncate policy clears the low address bits and loads from the aligned address. The check policy returns an alignment fault and no data. The split policy returns the correct operand, and uses a second word read when the operand crosses a word boundary. The memory model is a synchronous read port with one cycle of latency. Requests and responses each use a valid/ready handshake.

The control is a four-state machine:
- IDLE accepts a request. It moves to REPLY when the request faults and to FIRST otherwise.
- FIRST receives the first word. It moves to SECOND when a second read is needed and to REPLY otherwise.
- SECOND receives the upper word and then moves to REPLY.
- REPLY holds the response until the consumer takes it, then returns to IDLE.

Top module: `load_align_unit`

## Requirements
- R1: After reset the unit accepts requests (`req_ready`=1) and drives no response (`rsp_valid`=0) and no memory read (`mem_rd_en`=0).
- R2: `req_size` is coded 00 byte, 01 halfword and 10 word, with 11 treated as word. With `req_big_endian`=0, an operand of n bytes at address A has the value sum of byte(A+i)<<(8*i), where byte(X) is bits [8*(X mod 4)+7 : 8*(X mod 4)] of memory word X div 4.
- R3: With `req_big_endian`=1, byte(A) is the most significant byte of the operand and byte(A+n-1) is the least significant.
- R4: With `req_signed`=0, byte and halfword results are zero-extended to 32 bits. With `req_signed`=1, bit 7 (byte) or bit 15 (halfword) of the operand fills all the upper bits.
- R5: Under policy 00 (truncate), an unaligned halfword has address bit 0 forced to zero and an unaligned word has bits 1:0 forced to zero. The data comes from the aligned address and `rsp_fault` stays 0.
- R6: Under policy 01 (check) or 11 (reserved, treated as check), an unaligned access issues no memory read. Its response comes one cycle after acceptance with `rsp_fault`=1 and `rsp_data`=0.
- R7: Under policy 10 (split), an unaligned operand that crosses a word boundary is built from two reads at consecutive word-aligned addresses. An unaligned operand that stays inside one word takes a single read. Every memory read address has bits 1:0 equal to zero.
- R8: `req_ready` is high only while no request is in flight. The response becomes valid 1 cycle after acceptance for a fault, 2 cycles for a single read and 3 cycles for a split access.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the signals `rsp_valid`, `rsp_data` and `rsp_fault` stay unchanged.
- R10: An aligned access never faults, whatever the policy. Bytes are always aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A load request is offered |
| req_ready | output | 1 | The unit accepts a request this cycle |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| req_big_endian | input | 1 | 1 = most significant byte at the lowest address |
| req_policy | input | 2 | Unaligned-access policy code |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Word-aligned byte address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | A response is presented |
| rsp_ready | input | 1 | The consumer takes the response |
| rsp_data | output | 32 | Extended operand, zero on a fault |
| rsp_fault | output | 1 | The access was rejected as unaligned |

## Verification
The hardest path to reach is the SECOND state. It needs the split policy, an unaligned offset and a size large enough to cross into the next word, all in the same request, and it only counts when the bytes in the upper word differ from those in the lower word. The stimulus steps through every combination of policy, size, byte offset, sign flag and byte order on memory words whose bytes are all different, so every crossing and non-crossing case is covered. Two more loads hold `rsp_ready` low, one on a fault and one on a split access, so the REPLY hold is exercised on both the shortest and the longest path.

// File: rtl/ldal_pkg.sv
package ldal_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } ld_size_e;

    typedef enum logic [1:0] {
        POL_TRUNC = 2'b00,
        POL_CHECK = 2'b01,
        POL_SPLIT = 2'b10,
        POL_RSVD  = 2'b11
    } align_pol_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_REPLY
    } ld_state_e;
endpackage

// File: rtl/ldal_decode.sv
module ldal_decode
    import ldal_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  ld_size_e         size,
    input  align_pol_e       pol,
    output logic             misaligned,
    output logic             fault,
    output logic             split,
    output logic [OFF_W-1:0] eff_off
);
    logic [OFF_W:0]   nbytes;
    logic [OFF_W+1:0] span_end;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin misaligned = 1'b0;      nbytes = (OFF_W+1)'(1); end
            SZ_HALF: begin misaligned = offset[0]; nbytes = (OFF_W+1)'(2); end
            default: begin misaligned = |offset;   nbytes = (OFF_W+1)'(LANES); end
        endcase
        span_end = (OFF_W+2)'(offset) + (OFF_W+2)'(nbytes);
        fault    = misaligned && (pol == POL_CHECK || pol == POL_RSVD);
        split    = misaligned && (pol == POL_SPLIT) && (span_end > (OFF_W+2)'(LANES));
        if (misaligned && pol == POL_TRUNC)
            eff_off = (size == SZ_HALF) ? {offset[OFF_W-1:1], 1'b0} : '0;
        else
            eff_off = offset;
    end
endmodule

// File: rtl/ldal_ctrl.sv
module ldal_ctrl
    import ldal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      fault_now,
    input  logic      split_q,
    input  logic      rsp_ready,
    output ld_state_e state,
    output logic      req_ready,
    output logic      rsp_valid,
    output logic      accept,
    output logic      issue_first,
    output logic      issue_second,
    output logic      load_rsp
);
    ld_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = fault_now ? ST_REPLY : ST_FIRST;
            ST_FIRST:  state_nx = split_q ? ST_SECOND : ST_REPLY;
            ST_SECOND: state_nx = ST_REPLY;
            ST_REPLY:  if (rsp_ready) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        accept       = 1'b0;
        issue_first  = 1'b0;
        issue_second = 1'b0;
        load_rsp     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready   = 1'b1;
                accept      = req_valid;
                issue_first = req_valid && !fault_now;
            end
            ST_FIRST: begin
                issue_second = split_q;
                load_rsp     = !split_q;
            end
            ST_SECOND: load_rsp  = 1'b1;
            ST_REPLY:  rsp_valid = 1'b1;
        endcase
    end
endmodule

// File: rtl/ldal_extract.sv
module ldal_extract
    import ldal_pkg::*;
(
    input  logic [2*WORD_W-1:0] win,
    input  logic [OFF_W-1:0]    off,
    input  ld_size_e            size,
    input  logic                sgn,
    input  logic                big,
    output logic [WORD_W-1:0]   result
);
    logic [7:0]        lane [LANES];
    logic [WORD_W-1:0] raw;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = win[8*({1'b0, off} + (OFF_W+1)'(i)) +: 8];
    end

    always_comb begin
        raw = '0;
        unique case (size)
            SZ_BYTE: raw[7:0]  = lane[0];
            SZ_HALF: raw[15:0] = big ? {lane[0], lane[1]} : {lane[1], lane[0]};
            default: begin
                for (int k = 0; k < LANES; k++) begin
                    if (big) raw[8*(LANES-1-k) +: 8] = lane[k];
                    else     raw[8*k +: 8]           = lane[k];
                end
            end
        endcase
        result = raw;
        if (sgn && size == SZ_BYTE) result[WORD_W-1:8]  = {(WORD_W-8){raw[7]}};
        if (sgn && size == SZ_HALF) result[WORD_W-1:16] = {(WORD_W-16){raw[15]}};
    end
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
    import ldal_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_signed,
    input  logic          req_big_endian,
    input  logic [1:0]    req_policy,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [31:0]   mem_rd_data,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [31:0]   rsp_data,
    output logic          rsp_fault
);
    localparam int WA_W = AW - OFF_W;

    ld_state_e         state;
    logic              accept, issue_first, issue_second, load_rsp;
    logic              mis_now, fault_now, split_now;
    logic [OFF_W-1:0]  eff_now;

    logic [WA_W-1:0]   word_q;
    logic [OFF_W-1:0]  off_q;
    ld_size_e          size_q;
    logic              sgn_q, big_q, split_q;
    logic [WORD_W-1:0] low_q, data_q, extracted;
    logic              fault_q;
    logic [2*WORD_W-1:0] window;

    ldal_decode u_decode (
        .offset     (req_addr[OFF_W-1:0]),
        .size       (ld_size_e'(req_size)),
        .pol        (align_pol_e'(req_policy)),
        .misaligned (mis_now),
        .fault      (fault_now),
        .split      (split_now),
        .eff_off    (eff_now)
    );

    ldal_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .fault_now    (fault_now),
        .split_q      (split_q),
        .rsp_ready    (rsp_ready),
        .state        (state),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .accept       (accept),
        .issue_first  (issue_first),
        .issue_second (issue_second),
        .load_rsp     (load_rsp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            off_q   <= '0;
            size_q  <= SZ_BYTE;
            sgn_q   <= 1'b0;
            big_q   <= 1'b0;
            split_q <= 1'b0;
            low_q   <= '0;
            data_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            if (accept) begin
                word_q  <= req_addr[AW-1:OFF_W];
                off_q   <= eff_now;
                size_q  <= ld_size_e'(req_size);
                sgn_q   <= req_signed;
                big_q   <= req_big_endian;
                split_q <= split_now;
                fault_q <= fault_now;
                data_q  <= '0;
            end
            if (issue_second) low_q  <= mem_rd_data;
            if (load_rsp)     data_q <= extracted;
        end
    end

    assign window = (state == ST_SECOND) ? {mem_rd_data, low_q}
                                         : {{WORD_W{1'b0}}, mem_rd_data};

    ldal_extract u_extract (
        .win    (window),
        .off    (off_q),
        .size   (size_q),
        .sgn    (sgn_q),
        .big    (big_q),
        .result (extracted)
    );

    assign mem_rd_en   = issue_first || issue_second;
    assign mem_rd_addr = issue_second ? {word_q + WA_W'(1), {OFF_W{1'b0}}}
                                      : {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
    assign rsp_data    = data_q;
    assign rsp_fault   = fault_q;

    logic unused_mis;
    assign unused_mis = mis_now;
endmodule

// File: rtl/ldal_checker.sv
module ldal_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_off,
    input logic [1:0]    req_size,
    input logic [1:0]    req_policy,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [31:0]   rsp_data,
    input logic          rsp_fault
);
    logic req_unaligned, req_checking;
    assign req_unaligned = (req_size == 2'b01 && req_off[0]) || (req_size[1] && req_off != 2'b00);
    assign req_checking  = req_policy[0];

    assert_idle_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready && !mem_rd_en);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_fault));

    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_data == 32'd0);

    assert_fault_noread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_unaligned && req_checking |-> !mem_rd_en);

    assert_word_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_rd_addr[1:0] == 2'b00);

    assert_next_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && !req_ready |-> $past(mem_rd_en) && mem_rd_addr == $past(mem_rd_addr) + AW'(4));
endmodule

bind load_align_unit ldal_checker #(.AW(AW)) u_ldal_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_off     (req_addr[1:0]),
    .req_size    (req_size),
    .req_policy  (req_policy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_fault   (rsp_fault)
);

// File: tb/load_align_unit_bench.sv
`timescale 1ns/1ps
module load_align_unit_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_signed = 1'b0;
    logic          req_big_endian = 1'b0;
    logic [1:0]    req_policy = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [31:0]   rsp_data;
    logic          rsp_fault;

    always #5 clk = ~clk;

    load_align_unit #(.AW(AW)) u_load_align_unit (.*);

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] byte_of(int a);
        return 8'(((a & 255) * 29 + 131) & 255);
    endfunction

    logic [31:0] mem_w [64];
    initial begin
        for (int i = 0; i < 64; i++)
            mem_w[i] = {byte_of(4*i+3), byte_of(4*i+2), byte_of(4*i+1), byte_of(4*i)};
    end
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_w[mem_rd_addr[7:2]];

    // reference model: state held in plain variables, advanced on each rising edge
    bit          m_busy = 0;
    int          m_cnt = 0;
    int          m_reads = 0;
    int          m_exp_reads = 0;
    logic [31:0] m_data = '0;
    logic        m_fault = 1'b0;
    string       m_tag = "R2";
    bit          m_stall = 0;

    task automatic predict(int a, int sz, bit sg, bit bg, int pl);
        int n, ea;
        bit mis, split;
        logic [31:0] v;
        n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        mis = (a % n) != 0;
        if (mis && (pl == 1 || pl == 3)) begin
            m_data = 0; m_fault = 1; m_cnt = 0; m_exp_reads = 0; m_tag = "R6";
        end else begin
            ea = (mis && pl == 0) ? a - (a % n) : a;
            v = 0;
            for (int i = 0; i < n; i++) begin
                if (bg) v = (v << 8) | 32'(byte_of(ea + i));
                else    v = v | (32'(byte_of(ea + i)) << (8*i));
            end
            if (sg && n == 1 && v[7])  v = v | 32'hFFFF_FF00;
            if (sg && n == 2 && v[15]) v = v | 32'hFFFF_0000;
            split = mis && pl == 2 && ((ea % 4) + n > 4);
            m_data = v; m_fault = 0;
            m_cnt = split ? 2 : 1; m_exp_reads = split ? 2 : 1;
            if (split || (mis && pl == 2)) m_tag = "R7";
            else if (mis)                  m_tag = "R5";
            else if (pl != 0)              m_tag = "R10";
            else if (bg)                   m_tag = "R3";
            else if (sg && n < 4)          m_tag = "R4";
            else                           m_tag = "R2";
        end
        if (m_stall) m_tag = "R9";
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_reads = 0;
        end else if (m_busy) begin
            if (mem_rd_en) m_reads++;
            if (m_cnt > 0) m_cnt--;
            else if (rsp_ready) begin
                chk({m_tag, " reads"}, 32'(m_reads), 32'(m_exp_reads));
                m_busy = 0;
            end
        end else if (req_valid) begin
            predict(int'(req_addr), int'(req_size), req_signed, req_big_endian, int'(req_policy));
            m_reads = int'(mem_rd_en);
            m_busy = 1;
        end
    end

    // per-cycle comparison away from the active edge (R8 handshake and latency)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 req_ready", 32'(req_ready), 32'(!m_busy));
            chk("R8 rsp_valid", 32'(rsp_valid), 32'(m_busy && m_cnt == 0));
            if (m_busy && m_cnt == 0) begin
                chk({m_tag, " data"}, rsp_data, m_data);
                chk({m_tag, " fault"}, 32'(rsp_fault), 32'(m_fault));
            end
        end
    end

    task automatic do_load(int a, int sz, bit sg, bit bg, int pl, int stall);
        @(negedge clk);
        while (m_busy) @(negedge clk);
        #1;
        m_stall        = (stall > 0);
        req_addr       = AW'(a);
        req_size       = 2'(sz);
        req_signed     = sg;
        req_big_endian = bg;
        req_policy     = 2'(pl);
        rsp_ready      = (stall == 0);
        req_valid      = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (stall > 0) begin
            repeat (stall + 3) @(negedge clk);
            #1 rsp_ready = 1'b1;
        end
        while (m_busy) @(negedge clk);
        m_stall = 0;
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 mem_rd_en", 32'(mem_rd_en), 32'd0);

        for (int pl = 0; pl < 4; pl++)
            for (int sz = 0; sz < 3; sz++)
                for (int off = 0; off < 4; off++)
                    for (int sg = 0; sg < 2; sg++)
                        for (int bg = 0; bg < 2; bg++)
                            do_load(32 + 4*((pl*16 + sz*5 + off*3 + sg*2 + bg) % 40) + off,
                                    sz, bit'(sg), bit'(bg), pl, 0);

        do_load(70, 3, 0, 0, 2, 0);   // R2: size code 11 behaves as word
        do_load(88, 3, 1, 1, 0, 0);   // R2 with R3 ordering
        do_load(101, 2, 0, 0, 1, 2);  // R9: fault response held
        do_load(127, 2, 1, 1, 2, 3);  // R9: split response held

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule